// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block gathers a set of peripheral interrupt request lines and funnels them into a single interrupt line for a processor. It also supplies the number of the source that should be served first. Every request line passes through a synchronizer. Each line has its own enable bit and its own pending bit, and it can be set to work as either a level source or a qualified rising-edge source. A separate non-maskable line is intended for urgent events such as a power failure. That line raises the output no matter how the enables are programmed.

Software uses a plain read/write port with four registers:

| Address | Register | Content |
|---|---|---|
| 0 | per-source enable | one bit per source |
| 1 | sensitivity | 1 = edge, 0 = level |
| 2 | pending status | one bit per source |
| 3 | control | bit 0 is the global enable |

To acknowledge, software reads the status register and writes the same value back. The write clears only the bits that are written as 1. Among the requesting sources, the lowest-numbered one wins. The non-maskable line ranks above every source and is reported as number N_SRC.

Top module: `irq_hub`

## Requirements
- R1: After reset, the enable, sensitivity, status and control registers all read 0, irq_o is low, and irq_id_o is all ones.
- R2: An edge event on a source whose enable bit is 0 is dropped, not stored. Setting the enable bit afterwards leaves the status bit at 0 and irq_o low.
- R3: For a level source (sensitivity bit 0) that is enabled, the status bit follows the synchronized input. irq_o stays high as long as the input is high. A write-back to the status register has no effect on that bit.
- R4: For an edge source (sensitivity bit 1) that is enabled, a rising input that stays high for at least MIN_HIGH synchronized cycles sets the status bit. The bit stays set after the input falls.
- R5: A high pulse shorter than MIN_HIGH synchronized cycles does not set an edge source's status bit. The qualification count starts again whenever the input goes low.
- R6: Writing a value to the status register (address 2) clears exactly those edge-source status bits that are written as 1. All other status bits are unchanged.
- R7: Several status bits can be set at the same time, and all of them are visible in a single status read.
- R8: When more than one enabled source is pending, irq_id_o reports the lowest-numbered one.
- R9: While nmi_i is high, irq_o is high and irq_id_o equals N_SRC. This holds whatever the enable and control settings are, and it takes precedence over any pending source. The output follows nmi_i two clocks later.
- R10: Control bit 0, the global enable, gates every maskable source. While it is 0, pending sources do not raise irq_o but remain visible in the status register.
- R11: Whenever irq_o is low, irq_id_o is all ones.
- R12: If a qualified edge arrives on a source in the same cycle that a write-back clears its status bit, the bit stays set.
- R13: The enable, sensitivity and control registers read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Request lines from the peripherals |
| nmi_i | input | 1 | Non-maskable request |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | N_SRC | Write data |
| rdata_o | output | N_SRC | Read data for the register at addr_i |
| irq_o | output | 1 | Merged interrupt output |
| irq_id_o | output | ID_W | Number of the source to serve, or all ones when irq_o is low |

## Verification
The bench builds the block with its default parameters: eight sources, two synchronizer stages and MIN_HIGH of 2. With a window of 2, a one-cycle pulse falls just short of qualifying, and a four-cycle pulse clearly qualifies. That makes the pulse-width boundary of R5 directly testable. The small window also lets the bench place a write-back in exactly the cycle where a qualified edge lands, which exercises the collision rule of R12. Because eight sources give a 4-bit ID, the bench can tell the non-maskable code (8) apart from the idle code (15) and from the ordinary source numbers.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  typedef enum logic [1:0] {
    REG_MASK = 2'd0,
    REG_MODE = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic lvl_o,
  output logic evt_o
);
  localparam int CNT_W = (MIN_HIGH < 2) ? 1 : $clog2(MIN_HIGH);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   done_q, done_d;
  logic                   lvl;

  assign lvl = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], raw_i};
    cnt_d  = cnt_q;
    done_d = done_q;
    evt_o  = 1'b0;
    if (!lvl) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CNT_W'(MIN_HIGH - 1)) begin
        evt_o  = 1'b1;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign lvl_o = lvl;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N    = 8,
  parameter int ID_W = 4
) (
  input  logic [N-1:0]    req_i,
  output logic            any_o,
  output logic [ID_W-1:0] idx_o
);
  always_comb begin
    idx_o = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = ID_W'(i);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N_SRC       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 2,
  localparam int ID_W       = $clog2(N_SRC + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_i,
  input  logic             nmi_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [N_SRC-1:0] wdata_i,
  output logic [N_SRC-1:0] rdata_o,
  output logic             irq_o,
  output logic [ID_W-1:0]  irq_id_o
);
  logic rst_n_sync;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  logic [N_SRC-1:0] lvl, evt;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    irq_src_detect #(
      .SYNC_STAGES (SYNC_STAGES),
      .MIN_HIGH    (MIN_HIGH)
    ) u_det (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .raw_i (src_i[g]),
      .lvl_o (lvl[g]),
      .evt_o (evt[g])
    );
  end

  logic [SYNC_STAGES-1:0] nmi_q, nmi_d;
  logic                   nmi_lvl;

  logic [N_SRC-1:0] mask_q, mask_d;
  logic [N_SRC-1:0] mode_q, mode_d;
  logic [N_SRC-1:0] pend_q, pend_d;
  logic             gen_q, gen_d;
  logic [N_SRC-1:0] clr;
  logic             wr_mask, wr_mode, wr_stat, wr_ctrl;

  assign wr_mask = wr_en_i && (addr_i == REG_MASK);
  assign wr_mode = wr_en_i && (addr_i == REG_MODE);
  assign wr_stat = wr_en_i && (addr_i == REG_STAT);
  assign wr_ctrl = wr_en_i && (addr_i == REG_CTRL);
  assign clr     = wr_stat ? wdata_i : '0;
  assign nmi_lvl = nmi_q[SYNC_STAGES-1];

  always_comb begin
    nmi_d  = {nmi_q[SYNC_STAGES-2:0], nmi_i};
    mask_d = wr_mask ? wdata_i : mask_q;
    mode_d = wr_mode ? wdata_i : mode_q;
    gen_d  = wr_ctrl ? wdata_i[0] : gen_q;
    for (int i = 0; i < N_SRC; i++) begin
      if (mode_q[i]) pend_d[i] = (pend_q[i] & ~clr[i]) | (evt[i] & mask_q[i]);
      else           pend_d[i] = lvl[i] & mask_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      nmi_q  <= '0;
      mask_q <= '0;
      mode_q <= '0;
      pend_q <= '0;
      gen_q  <= 1'b0;
    end else begin
      nmi_q  <= nmi_d;
      mask_q <= mask_d;
      mode_q <= mode_d;
      pend_q <= pend_d;
      gen_q  <= gen_d;
    end
  end

  logic [N_SRC-1:0] req;
  logic             any_req;
  logic [ID_W-1:0]  pick;

  assign req = gen_q ? (pend_q & mask_q) : '0;

  irq_prio_pick #(.N(N_SRC), .ID_W(ID_W)) u_pick (
    .req_i (req),
    .any_o (any_req),
    .idx_o (pick)
  );

  always_comb begin
    irq_o = nmi_lvl | any_req;
    if (nmi_lvl)      irq_id_o = ID_W'(N_SRC);
    else if (any_req) irq_id_o = pick;
    else              irq_id_o = '1;
    case (reg_sel_e'(addr_i))
      REG_MASK: rdata_o = mask_q;
      REG_MODE: rdata_o = mode_q;
      REG_STAT: rdata_o = pend_q;
      default:  rdata_o = N_SRC'(gen_q);
    endcase
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int N_SRC = 8,
  parameter int ID_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nmi_i,
  input logic             irq_o,
  input logic [ID_W-1:0]  irq_id_o,
  input logic [N_SRC-1:0] pend_q,
  input logic [N_SRC-1:0] mode_q,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [N_SRC-1:0] wdata_i
);
  logic [2:0] age_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 1'b1;
  end
  assign warm = (age_q >= 3'd6);

  // R11: idle code whenever the output is low
  assert_idle_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_id_o == '1));

  // R8: a raised output always carries an in-range number
  assert_id_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_id_o <= ID_W'(N_SRC)));

  // R9: non-maskable request reaches the output two clocks later
  assert_nmi_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(nmi_i, 2)) |-> (irq_o && irq_id_o == ID_W'(N_SRC)));

  // R6: an edge-source pending bit only drops on a write-back of that bit
  assert_pending_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (($past(pend_q) & ~pend_q & $past(mode_q) &
               ~($past(wr_en_i && addr_i == 2'd2) ? $past(wdata_i) : N_SRC'(0))) == '0));
endmodule

bind irq_hub irq_hub_chk #(.N_SRC(N_SRC), .ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .nmi_i    (nmi_i),
  .irq_o    (irq_o),
  .irq_id_o (irq_id_o),
  .pend_q   (pend_q),
  .mode_q   (mode_q),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  localparam int N    = 8;
  localparam int ID_W = 4;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    src;
  logic            nmi;
  logic            wr_en;
  logic [1:0]      addr;
  logic [N-1:0]    wdata;
  logic [N-1:0]    rdata;
  logic            irq;
  logic [ID_W-1:0] irq_id;

  int n_tests = 0;
  int n_fail  = 0;

  irq_hub u_irq_hub (
    .clk(clk), .rst_n(rst_n), .src_i(src), .nmi_i(nmi),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .irq_id_o(irq_id)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input logic [N-1:0] bits, input int len);
    @(negedge clk);
    src = src | bits;
    repeat (len) @(negedge clk);
    src = src & ~bits;
  endtask

  task automatic t_reset;
    logic [N-1:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == '0, "R1 reg", v, 0);
    end
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(irq_id == '1, "R11 idle id", irq_id, 15);
  endtask

  task automatic t_regs;
    logic [N-1:0] v;
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd3, 8'h01);
    rd(2'd0, v); check(v == 8'hA5, "R13 mask", v, 8'hA5);
    rd(2'd1, v); check(v == 8'h3C, "R13 mode", v, 8'h3C);
    rd(2'd3, v); check(v == 8'h01, "R13 ctrl", v, 1);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd3, 8'h00);
  endtask

  task automatic t_level;
    logic [N-1:0] v;
    wr(2'd0, 8'h04); wr(2'd3, 8'h01);
    @(negedge clk); src[2] = 1'b1;
    settle(5);
    rd(2'd2, v); check(v == 8'h04, "R3 status", v, 4);
    check(irq == 1'b1 && irq_id == 4'd2, "R3 irq", {irq, irq_id}, 5'h12);
    wr(2'd2, 8'h04);
    settle(1);
    rd(2'd2, v); check(v == 8'h04, "R3 write-back ignored", v, 4);
    wr(2'd3, 8'h00);
    settle(1);
    check(irq == 1'b0, "R10 gated", irq, 0);
    rd(2'd2, v); check(v == 8'h04, "R10 still visible", v, 4);
    wr(2'd3, 8'h01);
    @(negedge clk); src[2] = 1'b0;
    settle(5);
    check(irq == 1'b0, "R3 drops", irq, 0);
    rd(2'd2, v); check(v == 8'h00, "R3 status clear", v, 0);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_edge;
    logic [N-1:0] v;
    wr(2'd1, 8'h20); wr(2'd0, 8'h20);
    pulse(8'h20, 4);
    settle(5);
    rd(2'd2, v); check(v == 8'h20, "R4 latched", v, 8'h20);
    check(irq == 1'b1 && irq_id == 4'd5, "R4 irq", {irq, irq_id}, 5'h15);
    wr(2'd2, 8'h20);
    settle(1);
    rd(2'd2, v); check(v == 8'h00, "R6 acked", v, 0);
    check(irq == 1'b0, "R6 irq low", irq, 0);
    pulse(8'h20, 1);
    settle(5);
    rd(2'd2, v); check(v == 8'h00, "R5 short pulse", v, 0);
  endtask

  task automatic t_masked;
    logic [N-1:0] v;
    wr(2'd1, 8'h01); wr(2'd0, 8'h00);
    pulse(8'h01, 4);
    settle(5);
    wr(2'd0, 8'h01);
    settle(2);
    rd(2'd2, v); check(v == 8'h00, "R2 discarded", v, 0);
    check(irq == 1'b0, "R2 irq", irq, 0);
  endtask

  task automatic t_multi;
    logic [N-1:0] v;
    wr(2'd1, 8'h52); wr(2'd0, 8'h52);
    pulse(8'h52, 4);
    settle(5);
    rd(2'd2, v); check(v == 8'h52, "R7 all visible", v, 8'h52);
    check(irq_id == 4'd1, "R8 lowest first", irq_id, 1);
    wr(2'd2, 8'h02); settle(1);
    rd(2'd2, v); check(v == 8'h50, "R6 exact clear", v, 8'h50);
    check(irq_id == 4'd4, "R8 next", irq_id, 4);
    wr(2'd2, 8'h10); settle(1);
    check(irq_id == 4'd6, "R8 last", irq_id, 6);
    wr(2'd2, 8'h40); settle(1);
    check(irq == 1'b0, "R6 all acked", irq, 0);
  endtask

  task automatic t_nmi;
    wr(2'd0, 8'h00); wr(2'd3, 8'h00);
    @(negedge clk); nmi = 1'b1;
    settle(3);
    check(irq == 1'b1 && irq_id == 4'd8, "R9 nmi", {irq, irq_id}, 5'h18);
    @(negedge clk); nmi = 1'b0;
    settle(3);
    check(irq == 1'b0 && irq_id == 4'hF, "R9 release", {irq, irq_id}, 5'h0F);
    wr(2'd3, 8'h01);
  endtask

  task automatic t_collide;
    logic [N-1:0] v;
    wr(2'd1, 8'h08); wr(2'd0, 8'h08);
    pulse(8'h08, 4);
    settle(5);
    @(negedge clk); src[3] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = 2'd2; wdata = 8'h08;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    rd(2'd2, v); check(v == 8'h08, "R12 new edge wins", v, 8'h08);
    src[3] = 1'b0;
    wr(2'd2, 8'h08); settle(1);
    rd(2'd2, v); check(v == 8'h00, "R12 later ack", v, 0);
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src = '0; nmi = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    settle(4);
    t_reset;
    t_regs;
    t_level;
    t_edge;
    t_masked;
    t_multi;
    t_nmi;
    t_collide;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule